// File: doc/BRIEF.md
# Sectionalized MDIO Management Slave

This block is the management-side serial slave of an eight-port PHY. It watches one or two MDC/MDIO channel pairs, decodes clause-22 style management frames, and turns each matching frame into a read or a write on a per-port register bank. A section-mode input chooses how the channels share the ports. With the mode low, channel 0 serves all eight ports. With the mode high, channel 0 serves ports 0 to 3 and channel 1 serves ports 4 to 7. Each section has its own open-drain interrupt output, which reports port status changes.

A management-disable input selects how the hardware strap pins and the serial channel share the low configuration bits. With the input high, the serial channel is off and the straps hold those bits directly. With the input low, the straps only give the reset value, and serial writes take over afterwards. During hardware reset and power-down, every MDIO and interrupt driver is released.

The serial pins are oversampled by the system clock. Edges of MDC are detected after a two-stage synchronizer. Data is sampled on MDC rising edges. Read data is launched after MDC falling edges.

Top module: `mdio_sect_slave`

## Requirements
- R1: While `rstN` is low and after it rises, `mdioOe` and `intPullLow` are all zero. Register 0 of every port resets to `strapCfg` in bits [3:0] with zeros above. Register 18 and the change latches reset to zero.
- R2: A frame is 32 or more ones, then start bits 0 and 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address and a 5-bit register address, all MSB first. On a write, a 2-bit turnaround follows, then 16 data bits MSB first. On a read, the slave leaves the first turnaround bit undriven, drives 0 for the second, drives 16 data bits MSB first, and then releases the line.
- R3: The port index is the PHY address minus `PHY_BASE` (default 8). A frame whose address falls outside the channel's port range is not driven and writes nothing.
- R4: With `sect2x4` = 0, channel 0 reaches ports 0 to 7. Frames on channel 1 are neither answered nor applied.
- R5: With `sect2x4` = 1, channel 0 reaches only ports 0 to 3 and channel 1 reaches only ports 4 to 7.
- R6: Register 0 is 16-bit read/write. Register 18 is 16-bit read/write, and its bit 1 is the interrupt enable. Register 19 is read-only, with bit 0 as the port's change latch and the other bits 0. Every other register address reads 0 and ignores writes.
- R7: A change in level of `portStatus[p]` sets the change latch of port p. `intPullLow[s]` is 1 while any port of section s has its latch set and register 18 bit 1 set. With `sect2x4` = 0, section 0 covers all eight ports and `intPullLow[1]` stays 0.
- R8: A read of register 19 returns the latch value and then clears the latch, which releases the interrupt.
- R9: While `mdDisable` is 1, frames are neither answered nor applied, and register 0 bits [3:0] of every port follow `strapCfg`.
- R10: With `mdDisable` at 0, a change of `strapCfg` after reset has no effect, and serial writes set register 0 bits [3:0].
- R11: While `powerDown` is 1, `mdioOe` and `intPullLow` are zero and frames are ignored. Pending latches are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples MDC |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| powerDown | input | 1 | Hardware power-down, releases all outputs |
| mdDisable | input | 1 | High: serial channel off, straps hold bits |
| sect2x4 | input | 1 | 0: one channel serves 8 ports; 1: two channels of 4 |
| strapCfg | input | STRAP_W | Strap pin levels for register 0 low bits |
| portStatus | input | NUM_PORTS | Per-port status level, change sets latch |
| mdc | input | 2 | Management clock per channel |
| mdioIn | input | 2 | Management data input per channel |
| mdioOut | output | 2 | Management data output value per channel |
| mdioOe | output | 2 | Management data output enable per channel |
| intPullLow | output | 2 | Per-section open-drain interrupt, 1 pulls the line low |

## Verification
A wrong frame state or bit count shows up as a wrong turnaround or a misaligned data word on the very next read. The misplaced drive appears within one MDC period. A wrong section decode shows as a channel that answers an address it does not own, or as a write landing in the wrong port. This is seen on the first read-back after the write. Latch or enable errors show on `intPullLow` within two system clocks of a status toggle, or as a register 19 value that fails to clear on a second read.

// File: rtl/mdio_sect_pkg.sv
package mdio_sect_pkg;
  localparam int DATA_W     = 16;
  localparam int REG_ADDR_W = 5;
  localparam int PORT_IDX_W = 3;
  localparam int NUM_SECT   = 2;

  localparam logic [REG_ADDR_W-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_ADDR_W-1:0] REG_IEN  = 5'd18;
  localparam logic [REG_ADDR_W-1:0] REG_STAT = 5'd19;
  localparam int IEN_BIT = 1;

  typedef struct packed {
    logic                  wr;
    logic                  rd;
    logic [PORT_IDX_W-1:0] port;
    logic [REG_ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0]     wdata;
  } mgmtReq_t;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_sect_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int PHY_BASE     = 8,
  parameter int CH_IDX       = 0,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chEnable,
  input  logic              sect2x4,
  input  logic              mdcIn,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] rdData,
  output mgmtReq_t          req,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PREAMBLE_LEN);
  localparam int HALF = NUM_PORTS / 2;
  localparam int HDR_BITS = 2 + 5 + REG_ADDR_W;

  typedef enum logic [2:0] {S_PRE, S_START, S_HDR, S_WBODY, S_RD} frameSt_t;

  frameSt_t          st;
  logic [2:0]        mdcSh;
  logic [1:0]        dSh;
  logic [PRE_W-1:0]  preCnt;
  logic [4:0]        cnt;
  logic [4:0]        fCnt;
  logic [HDR_BITS-1:0] hdr, hdrFull;
  logic [DATA_W-1:0] wSh, outSh;
  logic              riseE, fallE, bitIn, addrHit;
  logic [5:0]        phyOff, secLo, secSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcSh <= '0;
      dSh   <= '1;
    end else begin
      mdcSh <= {mdcSh[1:0], mdcIn};
      dSh   <= {dSh[0], mdioIn};
    end
  end

  assign riseE   = mdcSh[1] & ~mdcSh[2];
  assign fallE   = ~mdcSh[1] & mdcSh[2];
  assign bitIn   = dSh[1];
  assign hdrFull = {hdr[HDR_BITS-2:0], bitIn};

  always_comb begin
    secSize = sect2x4 ? 6'(HALF) : 6'(NUM_PORTS);
    secLo   = (sect2x4 && CH_IDX == 1) ? 6'(HALF) : 6'd0;
    phyOff  = {1'b0, hdrFull[9:5]} - 6'(PHY_BASE);
    addrHit = ({1'b0, hdrFull[9:5]} >= 6'(PHY_BASE)) && (phyOff >= secLo) &&
              (phyOff < secLo + secSize);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !chEnable) begin
      st <= S_PRE; preCnt <= '0; cnt <= '0; fCnt <= '0;
      hdr <= '0; wSh <= '0; outSh <= '0; req <= '0;
      mdioOut <= 1'b0; mdioOe <= 1'b0;
    end else begin
      req.wr <= 1'b0;
      req.rd <= 1'b0;
      if (req.rd) outSh <= rdData;
      case (st)
        S_PRE: if (riseE) begin
          if (bitIn) begin
            if (preCnt != PRE_MAX) preCnt <= preCnt + 1'b1;
          end else begin
            preCnt <= '0;
            if (preCnt == PRE_MAX) st <= S_START;
          end
        end
        S_START: if (riseE) begin
          cnt <= '0;
          st  <= bitIn ? S_HDR : S_PRE;
        end
        S_HDR: if (riseE) begin
          hdr <= hdrFull;
          cnt <= cnt + 1'b1;
          if (cnt == 5'(HDR_BITS - 1)) begin
            cnt         <= '0;
            fCnt        <= '0;
            req.port    <= phyOff[PORT_IDX_W-1:0];
            req.regAddr <= hdrFull[REG_ADDR_W-1:0];
            if (addrHit && hdrFull[11:10] == 2'b01) st <= S_WBODY;
            else if (addrHit && hdrFull[11:10] == 2'b10) begin
              st     <= S_RD;
              req.rd <= 1'b1;
            end else st <= S_PRE;
          end
        end
        S_WBODY: if (riseE) begin
          wSh <= {wSh[DATA_W-2:0], bitIn};
          cnt <= cnt + 1'b1;
          if (cnt == 5'(DATA_W + 1)) begin
            req.wr    <= 1'b1;
            req.wdata <= {wSh[DATA_W-2:0], bitIn};
            st        <= S_PRE;
          end
        end
        S_RD: if (fallE) begin
          fCnt <= fCnt + 1'b1;
          if (fCnt == 5'd1) begin
            mdioOe  <= 1'b1;
            mdioOut <= 1'b0;
          end else if (fCnt >= 5'd2 && fCnt <= 5'(DATA_W + 1)) begin
            mdioOut <= outSh[DATA_W-1];
            outSh   <= {outSh[DATA_W-2:0], 1'b0};
          end else if (fCnt == 5'(DATA_W + 2)) begin
            mdioOe <= 1'b0;
            st     <= S_PRE;
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end

  // R2: the slave only drives while answering a read
  assert_drive_only_in_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> st == S_RD);
  // R2: a frame is either a read or a write, never both
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(req.wr && req.rd));
  // R9/R11: a disabled channel lets go of the line on the next clock
  assert_release_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chEnable |=> !mdioOe);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_sect_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int STRAP_W   = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               mdDisable,
  input  logic                               sect2x4,
  input  logic [STRAP_W-1:0]                 strapCfg,
  input  logic [NUM_PORTS-1:0]               portStatus,
  input  mgmtReq_t [NUM_SECT-1:0]            req,
  output logic [NUM_SECT-1:0][DATA_W-1:0]    rdData,
  output logic [NUM_SECT-1:0]                intPend
);
  localparam int HALF = NUM_PORTS / 2;

  logic [DATA_W-1:0]    ctrlR [NUM_PORTS];
  logic [DATA_W-1:0]    ienR  [NUM_PORTS];
  logic [DATA_W-1:0]    wdSel [NUM_PORTS];
  logic [NUM_PORTS-1:0] chgLatch, prevSt, stChange, clrHit, wrCtrl, wrIen, pend;

  assign stChange = portStatus ^ prevSt;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      wrCtrl[p] = 1'b0; wrIen[p] = 1'b0; clrHit[p] = 1'b0; wdSel[p] = '0;
      for (int c = 0; c < NUM_SECT; c++) begin
        if (req[c].port == PORT_IDX_W'(p)) begin
          if (req[c].wr && req[c].regAddr == REG_CTRL) begin
            wrCtrl[p] = 1'b1; wdSel[p] = req[c].wdata;
          end
          if (req[c].wr && req[c].regAddr == REG_IEN) begin
            wrIen[p] = 1'b1; wdSel[p] = req[c].wdata;
          end
          if (req[c].rd && req[c].regAddr == REG_STAT) clrHit[p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSt   <= portStatus;
      chgLatch <= '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        ctrlR[p] <= DATA_W'(strapCfg);
        ienR[p]  <= '0;
      end
    end else begin
      prevSt   <= portStatus;
      chgLatch <= stChange | (chgLatch & ~clrHit);
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wrCtrl[p]) ctrlR[p] <= wdSel[p];
        if (mdDisable) ctrlR[p][STRAP_W-1:0] <= strapCfg;
        if (wrIen[p]) ienR[p] <= wdSel[p];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_SECT; c++) begin
      case (req[c].regAddr)
        REG_CTRL: rdData[c] = ctrlR[req[c].port];
        REG_IEN:  rdData[c] = ienR[req[c].port];
        REG_STAT: rdData[c] = DATA_W'(chgLatch[req[c].port]);
        default:  rdData[c] = '0;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPend
    assign pend[p] = chgLatch[p] & ienR[p][IEN_BIT];
  end
  assign intPend[0] = sect2x4 ? |pend[HALF-1:0] : |pend;
  assign intPend[1] = sect2x4 & |pend[NUM_PORTS-1:HALF];

  // R4: channel 1 issues nothing while one channel serves all ports
  assert_ch1_quiet_1x8_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sect2x4 && !$past(sect2x4)) |-> !(req[1].wr || req[1].rd));
  // R5: each channel stays inside its own half in split mode
  assert_ch0_lower_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sect2x4 && $past(sect2x4) && (req[0].wr || req[0].rd)) |-> req[0].port < PORT_IDX_W'(HALF));
  assert_ch1_upper_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sect2x4 && $past(sect2x4) && (req[1].wr || req[1].rd)) |-> req[1].port >= PORT_IDX_W'(HALF));
  // R8: a status read empties the latch unless a new change arrives
  assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (req[0].rd && req[0].regAddr == REG_STAT && !stChange[req[0].port])
      |=> !chgLatch[$past(req[0].port)]);
  // R9: with management disabled the straps hold the low bits
  assert_strap_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    mdDisable |=> ctrlR[0][STRAP_W-1:0] == $past(strapCfg));
endmodule

// File: rtl/mdio_sect_slave.sv
module mdio_sect_slave
  import mdio_sect_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int PHY_BASE     = 8,
  parameter int STRAP_W      = 4,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 powerDown,
  input  logic                 mdDisable,
  input  logic                 sect2x4,
  input  logic [STRAP_W-1:0]   strapCfg,
  input  logic [NUM_PORTS-1:0] portStatus,
  input  logic [1:0]           mdc,
  input  logic [1:0]           mdioIn,
  output logic [1:0]           mdioOut,
  output logic [1:0]           mdioOe,
  output logic [1:0]           intPullLow
);
  mgmtReq_t [NUM_SECT-1:0]         req;
  logic [NUM_SECT-1:0][DATA_W-1:0] rdData;
  logic [NUM_SECT-1:0]             oeRaw, intRaw, chEnable;
  logic                            padLive;

  assign padLive = rstN & ~powerDown;

  for (genvar c = 0; c < NUM_SECT; c++) begin : gCh
    assign chEnable[c] = padLive & ~mdDisable & ((c == 0) | sect2x4);
    mdio_frame_ctrl #(
      .NUM_PORTS(NUM_PORTS), .PHY_BASE(PHY_BASE),
      .CH_IDX(c), .PREAMBLE_LEN(PREAMBLE_LEN)
    ) uCtrl (
      .clk(clk), .rstN(rstN), .chEnable(chEnable[c]), .sect2x4(sect2x4),
      .mdcIn(mdc[c]), .mdioIn(mdioIn[c]), .rdData(rdData[c]),
      .req(req[c]), .mdioOut(mdioOut[c]), .mdioOe(oeRaw[c])
    );
  end

  mdio_reg_bank #(.NUM_PORTS(NUM_PORTS), .STRAP_W(STRAP_W)) uBank (
    .clk(clk), .rstN(rstN), .mdDisable(mdDisable), .sect2x4(sect2x4),
    .strapCfg(strapCfg), .portStatus(portStatus), .req(req),
    .rdData(rdData), .intPend(intRaw)
  );

  assign mdioOe     = oeRaw & {NUM_SECT{padLive}};
  assign intPullLow = intRaw & {NUM_SECT{padLive}};
endmodule

// File: tb/mdio_sect_slave_test.sv
module mdio_sect_slave_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0, powerDown = 1'b0, mdDisable = 1'b0, sect2x4 = 1'b0;
  logic [3:0] strapCfg = 4'h5;
  logic [7:0] portStatus = 8'h00;
  logic [1:0] mdc = 2'b00, mdioIn = 2'b11;
  logic [1:0] mdioOut, mdioOe, intPullLow;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  mdio_sect_slave uut (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .mdDisable(mdDisable),
    .sect2x4(sect2x4), .strapCfg(strapCfg), .portStatus(portStatus),
    .mdc(mdc), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .intPullLow(intPullLow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bitCycle(input int ch, input logic v, output logic sOe, output logic sVal);
    mdioIn[ch] = v;
    repeat (4) @(negedge clk);
    sOe = mdioOe[ch]; sVal = mdioOut[ch];
    mdc[ch] = 1'b1;
    repeat (4) @(negedge clk);
    mdc[ch] = 1'b0;
  endtask

  task automatic doFrame(input int ch, input bit isRd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rv, output bit drove, output bit protoOk);
    logic o, v, o1, o2, v2;
    logic [13:0] hdr;
    hdr = {2'b01, (isRd ? 2'b10 : 2'b01), phy, ra};
    drove = 1'b0; rv = '0; protoOk = 1'b1;
    for (int i = 0; i < 32; i++) bitCycle(ch, 1'b1, o, v);
    for (int i = 13; i >= 0; i--) bitCycle(ch, hdr[i], o, v);
    if (isRd) begin
      bitCycle(ch, 1'b1, o1, v);
      bitCycle(ch, 1'b1, o2, v2);
      drove = o1 | o2;
      for (int i = 15; i >= 0; i--) begin
        bitCycle(ch, 1'b1, o, v);
        rv[i] = o ? v : 1'b1;
        drove |= o;
      end
      bitCycle(ch, 1'b1, o, v);
      protoOk = !o1 && o2 && !v2 && !o;
    end else begin
      bitCycle(ch, 1'b1, o, v);
      bitCycle(ch, 1'b0, o, v);
      for (int i = 15; i >= 0; i--) bitCycle(ch, wd[i], o, v);
    end
    mdioIn[ch] = 1'b1;
  endtask

  task automatic wrReg(input int ch, input int port, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rv; bit d, p;
    doFrame(ch, 1'b0, 5'(8 + port), ra, wd, rv, d, p);
  endtask

  task automatic expRead(input int ch, input int phy, input logic [4:0] ra, input logic [15:0] exp, input string tag);
    logic [15:0] rv; bit d, p;
    doFrame(ch, 1'b1, 5'(phy), ra, 16'h0, rv, d, p);
    chk(d && p, {tag, " turnaround/release"}, {30'b0, d, p}, 32'h3);
    chk(rv == exp, tag, rv, exp);
  endtask

  task automatic expSilent(input int ch, input int phy, input logic [4:0] ra, input string tag);
    logic [15:0] rv; bit d, p;
    doFrame(ch, 1'b1, 5'(phy), ra, 16'h0, rv, d, p);
    chk(!d, tag, d, 0);
  endtask

  function automatic logic [15:0] patt(input int p, input int salt);
    return 16'(16'h0F00 ^ (p * 16'h1357) ^ (salt * 16'h2222));
  endfunction

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(mdioOe == 2'b00 && intPullLow == 2'b00, "R1 outputs released in reset", {mdioOe, intPullLow}, 0);
    doReset();
    chk(mdioOe == 2'b00 && intPullLow == 2'b00, "R1 outputs released after reset", {mdioOe, intPullLow}, 0);
    expRead(0, 8, 5'd0, 16'h0005, "R1 reg0 port0 reset from strap");
    expRead(0, 15, 5'd18, 16'h0000, "R1 reg18 port7 reset");

    // R10: straps are reset defaults only
    strapCfg = 4'h3;
    expRead(0, 8, 5'd0, 16'h0005, "R10 strap change after reset ignored");
    wrReg(0, 0, 5'd0, 16'h123C);
    expRead(0, 8, 5'd0, 16'h123C, "R10 serial write owns strap bits");

    // R2/R4: single channel sweep over all eight ports
    for (int p = 0; p < 8; p++) wrReg(0, p, 5'd0, patt(p, 1));
    for (int p = 0; p < 8; p++) expRead(0, 8 + p, 5'd0, patt(p, 1), $sformatf("R4 ch0 port%0d reg0", p));
    // R4: channel 1 ignored in one-channel mode
    expSilent(1, 12, 5'd0, "R4 ch1 silent in 1x8");
    wrReg(1, 4, 5'd0, 16'hDEAD);
    expRead(0, 12, 5'd0, patt(4, 1), "R4 ch1 write ignored in 1x8");

    // R3: addresses outside the port range
    expSilent(0, 7, 5'd0, "R3 phy below base not answered");
    expSilent(0, 16, 5'd0, "R3 phy above range not answered");

    // R6: register map
    wrReg(0, 2, 5'd18, 16'hBEEF);
    expRead(0, 10, 5'd18, 16'hBEEF, "R6 reg18 read/write");
    wrReg(0, 2, 5'd7, 16'hFFFF);
    expRead(0, 10, 5'd7, 16'h0000, "R6 unmapped reg reads zero");
    wrReg(0, 3, 5'd19, 16'hFFFF);
    expRead(0, 11, 5'd19, 16'h0000, "R6 reg19 read-only");

    // R7/R8: interrupts in one-channel mode
    doReset();
    wrReg(0, 6, 5'd18, 16'h0002);
    portStatus[6] = ~portStatus[6];
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b01, "R7 int0 on enabled port6 change", intPullLow, 2'b01);
    expRead(0, 14, 5'd19, 16'h0001, "R8 reg19 shows latch");
    chk(intPullLow == 2'b00, "R8 int released after status read", intPullLow, 2'b00);
    portStatus[1] = ~portStatus[1];
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b00, "R7 no int when enable bit clear", intPullLow, 2'b00);
    expRead(0, 9, 5'd19, 16'h0001, "R7 latch set without enable");
    expRead(0, 9, 5'd19, 16'h0000, "R8 latch cleared by read");

    // R5: two-channel sweep
    doReset();
    sect2x4 = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 8; p++) wrReg(p / 4, p, 5'd0, patt(p, 2));
    for (int p = 0; p < 8; p++) expRead(p / 4, 8 + p, 5'd0, patt(p, 2), $sformatf("R5 ch%0d port%0d reg0", p / 4, p));
    expSilent(0, 13, 5'd0, "R5 ch0 cannot reach port5");
    expSilent(1, 8, 5'd0, "R5 ch1 cannot reach port0");
    wrReg(0, 5, 5'd0, 16'h4444);
    expRead(1, 13, 5'd0, patt(5, 2), "R5 ch0 write to port5 ignored");

    // R7/R8: per-section interrupts in split mode
    wrReg(1, 5, 5'd18, 16'h0002);
    wrReg(0, 2, 5'd18, 16'h0002);
    portStatus[5] = ~portStatus[5];
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b10, "R7 int1 for port5 in 2x4", intPullLow, 2'b10);
    portStatus[2] = ~portStatus[2];
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b11, "R7 both sections pending", intPullLow, 2'b11);
    expRead(1, 13, 5'd19, 16'h0001, "R8 ch1 reads port5 latch");
    chk(intPullLow == 2'b01, "R8 int1 released", intPullLow, 2'b01);

    // R11: power-down releases and ignores
    powerDown = 1'b1;
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b00, "R11 int released in power-down", intPullLow, 2'b00);
    expSilent(0, 8, 5'd0, "R11 no answer in power-down");
    wrReg(0, 0, 5'd0, 16'h7777);
    powerDown = 1'b0;
    repeat (2) @(negedge clk);
    chk(intPullLow == 2'b01, "R11 latch kept through power-down", intPullLow, 2'b01);
    expRead(0, 8, 5'd0, patt(0, 2), "R11 write in power-down ignored");

    // R9: management disabled, straps in control
    wrReg(0, 0, 5'd0, 16'h1230);
    mdDisable = 1'b1;
    strapCfg = 4'hA;
    repeat (3) @(negedge clk);
    expSilent(0, 8, 5'd0, "R9 no answer while disabled");
    wrReg(0, 0, 5'd0, 16'hFFF0);
    mdDisable = 1'b0;
    repeat (2) @(negedge clk);
    expRead(0, 8, 5'd0, 16'h123A, "R9 strap held bits, write ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule